// File: doc/BRIEF.md
# Two-stage periodic timer

This block produces periodic timeouts on four channels. Each period comes from two cascaded down-counters. Two shared 8-bit prescalers divide the bus clock into two tick streams. Each of four 16-bit channel counters follows one of those streams, chosen by a per-channel select bit, so a channel spans a 24-bit range of periods.

Each expiry does three things: it reloads the channel, sets that channel's sticky flag, and emits a one-clock trigger pulse for other hardware. The flags, masked by a per-channel enable, are ORed into one interrupt request. All configuration goes through a plain register port, which writes in a single cycle and reads combinationally. The register port is control, not a data stream, so it has no valid/ready handshake.

Address map (AW = 4 bits for four channels):
- 0: control. Bit 0 is the global run bit. Bits 1 and 2 force-load prescaler 0 and 1.
- 1: channel force-load, bits 3:0.
- 2: channel enable.
- 3: prescaler select. Bit i = 1 means channel i follows prescaler 1.
- 4: interrupt enable.
- 5: flags.
- 6, 7: prescaler 0 and 1 load values.
- 8+2i: load value of channel i.
- 9+2i: read-only count of channel i.

Top module: `dual_stage_pit`

## Requirements
- R1: After reset every readable register is zero, `irq` is 0 and `trig` is 0.
- R2: With prescaler load M and channel load C, timeouts repeat every (M+1)*(C+1) clocks. When the channel starts with count C on an idle prescaler, the first timeout comes 1+(M+1)*(C+1) clocks after the enabling write.
- R3: A channel whose select bit (address 3, bit i) is 1 counts ticks of prescaler 1 and ignores prescaler 0.
- R4: A channel counts only while control bit 0 and its enable bit (address 2, bit i) are both 1. Otherwise its count holds its value.
- R5: Writing 1 to a flag bit (address 5) clears it. Writing 0 leaves it unchanged. A flag is set only by a timeout.
- R6: `irq` is 1 exactly when some flag bit and the matching interrupt-enable bit (address 4) are both 1.
- R7: A timeout sets the channel's flag and raises `trig[i]` for one clock, both visible after the same clock edge.
- R8: Writing 1 to bit i of address 1 loads channel i's count from its load register. This sets no flag and pulses no trigger, and address 1 reads back as zero.
- R9: Writing 1 to bit 1 or 2 of address 0 restarts that prescaler from its load value without a tick. Those bits read back as zero.
- R10: When a timeout and a write-1 clear of the same flag fall on one edge, the flag ends up set.
- R11: Writes to count addresses (9+2i) have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Combinational read data |
| irq | output | 1 | Interrupt request |
| trig | output | NCH | One-clock timeout pulses per channel |

## Verification
The collision that matters is a channel timeout landing on the same clock edge as a software write that clears that channel's flag. The bench runs a channel on a four-clock period and aligns to its trigger pulse. It clears the flag once, then issues a second clear timed to hit exactly four edges later. It judges the outcome at the `irq` pin, which must stay high because the set wins. A second collision, a prescaler force-load arriving on a counting edge, is judged by the stretched spacing of the trigger pulses.

// File: rtl/dual_stage_pit_pkg.sv
package dual_stage_pit_pkg;
  localparam int unsigned NPS      = 2;
  localparam int unsigned A_CTRL   = 0;
  localparam int unsigned A_CHFRC  = 1;
  localparam int unsigned A_CHEN   = 2;
  localparam int unsigned A_SEL    = 3;
  localparam int unsigned A_IEN    = 4;
  localparam int unsigned A_FLAG   = 5;
  localparam int unsigned A_PLD0   = 6;
  localparam int unsigned A_CHBASE = 8;

  function automatic int unsigned a_ld(int unsigned i);
    return A_CHBASE + 2 * i;
  endfunction

  function automatic int unsigned a_cnt(int unsigned i);
    return A_CHBASE + 2 * i + 1;
  endfunction
endpackage

// File: rtl/dsp_prescaler.sv
module dsp_prescaler #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [PW-1:0] load,
  input  logic          force_ld,
  output logic          tick
);
  logic [PW-1:0] cnt_q;
  logic          live_q;

  // live_q marks a counter that was already running on the previous clock
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      live_q <= 1'b0;
    end else begin
      live_q <= active;
      if (active) begin
        if (!live_q || force_ld || cnt_q == '0) cnt_q <= load;
        else                                     cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign tick = active && live_q && !force_ld && (cnt_q == '0);
endmodule

// File: rtl/dsp_chan_timer.sv
module dsp_chan_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          tick,
  input  logic [CW-1:0] load,
  input  logic          force_ld,
  output logic [CW-1:0] count,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (force_ld)       cnt_q <= load;
    else if (go && tick)     cnt_q <= (cnt_q == '0) ? load : cnt_q - 1'b1;
  end

  assign count  = cnt_q;
  assign expire = go && tick && !force_ld && (cnt_q == '0);
endmodule

// File: rtl/dual_stage_pit.sv
module dual_stage_pit
  import dual_stage_pit_pkg::*;
#(
  parameter  int NCH = 4,
  parameter  int CW  = 16,
  parameter  int PW  = 8,
  parameter  int DW  = 16,
  localparam int AW  = $clog2(A_CHBASE + 2 * NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic           irq,
  output logic [NCH-1:0] trig
);
  logic                    run_q;
  logic [NCH-1:0]          chen_q, sel_q, ien_q, flag_q, trig_q;
  logic [NPS-1:0][PW-1:0]  pld_q;
  logic [NCH-1:0][CW-1:0]  ld_q, cnt;
  logic [NCH-1:0]          frc_ch, timeout, ch_go, tick_sel;
  logic [NPS-1:0]          frc_ps, ps_active, ps_tick;
  logic [NCH-1:0]          flag_clr;

  function automatic logic hit(input logic en, input logic [AW-1:0] a, input int unsigned t);
    return en && (a == AW'(t));
  endfunction

  // Write decode of the self-clearing force bits and the flag clear mask
  always_comb begin
    frc_ch   = hit(wr_en, wr_addr, A_CHFRC) ? wr_data[NCH-1:0] : '0;
    frc_ps   = hit(wr_en, wr_addr, A_CTRL)  ? wr_data[NPS:1]   : '0;
    flag_clr = hit(wr_en, wr_addr, A_FLAG)  ? wr_data[NCH-1:0] : '0;
  end

  assign ch_go = {NCH{run_q}} & chen_q;

  for (genvar m = 0; m < NPS; m++) begin : g_ps
    assign ps_active[m] = |(ch_go & ((m == 1) ? sel_q : ~sel_q));
    dsp_prescaler #(.PW(PW)) u_ps (
      .clk(clk), .rst_n(rst_n), .active(ps_active[m]),
      .load(pld_q[m]), .force_ld(frc_ps[m]), .tick(ps_tick[m])
    );
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign tick_sel[i] = sel_q[i] ? ps_tick[1] : ps_tick[0];
    dsp_chan_timer #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .go(ch_go[i]), .tick(tick_sel[i]),
      .load(ld_q[i]), .force_ld(frc_ch[i]), .count(cnt[i]), .expire(timeout[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      chen_q <= '0;
      sel_q  <= '0;
      ien_q  <= '0;
      flag_q <= '0;
      trig_q <= '0;
      pld_q  <= '0;
      ld_q   <= '0;
    end else begin
      if (hit(wr_en, wr_addr, A_CTRL)) run_q  <= wr_data[0];
      if (hit(wr_en, wr_addr, A_CHEN)) chen_q <= wr_data[NCH-1:0];
      if (hit(wr_en, wr_addr, A_SEL))  sel_q  <= wr_data[NCH-1:0];
      if (hit(wr_en, wr_addr, A_IEN))  ien_q  <= wr_data[NCH-1:0];
      for (int m = 0; m < NPS; m++)
        if (hit(wr_en, wr_addr, A_PLD0 + m)) pld_q[m] <= wr_data[PW-1:0];
      for (int i = 0; i < NCH; i++)
        if (hit(wr_en, wr_addr, a_ld(i))) ld_q[i] <= wr_data[CW-1:0];
      // a timeout on the same edge as a clear wins
      flag_q <= (flag_q & ~flag_clr) | timeout;
      trig_q <= timeout;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(A_CTRL)) rd_data = DW'(run_q);
    if (rd_addr == AW'(A_CHEN)) rd_data = DW'(chen_q);
    if (rd_addr == AW'(A_SEL))  rd_data = DW'(sel_q);
    if (rd_addr == AW'(A_IEN))  rd_data = DW'(ien_q);
    if (rd_addr == AW'(A_FLAG)) rd_data = DW'(flag_q);
    for (int m = 0; m < NPS; m++)
      if (rd_addr == AW'(A_PLD0 + m)) rd_data = DW'(pld_q[m]);
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr == AW'(a_ld(i)))  rd_data = DW'(ld_q[i]);
      if (rd_addr == AW'(a_cnt(i))) rd_data = DW'(cnt[i]);
    end
  end

  assign irq  = |(flag_q & ien_q);
  assign trig = trig_q;
endmodule

// File: rtl/dual_stage_pit_chk.sv
module dual_stage_pit_chk #(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   irq,
  input logic [NCH-1:0]         trig,
  input logic [NCH-1:0]         flag,
  input logic [NCH-1:0]         ien,
  input logic [NCH-1:0]         ch_go,
  input logic [NCH-1:0]         ch_frc,
  input logic [NCH-1:0][CW-1:0] cnt
);
  assert_irq_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag & ien) == '0) |-> !irq);
  assert_irq_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag & ien) != '0) |-> irq);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    assert_trig_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      trig[i] |-> flag[i]);
    assert_flag_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[i]) |-> trig[i]);
    assert_force_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ch_frc[i] |=> !trig[i]);
    assert_hold_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_go[i] && !ch_frc[i]) |=> $stable(cnt[i]));
  end
endmodule

bind dual_stage_pit dual_stage_pit_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .trig(trig), .flag(flag_q),
  .ien(ien_q), .ch_go(ch_go), .ch_frc(frc_ch), .cnt(cnt)
);

// File: tb/dual_stage_pit_test.sv
`timescale 1ns/100ps
module dual_stage_pit_test;
  localparam int AW = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          irq;
  logic [3:0]    trig;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  dual_stage_pit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .trig(trig)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = AW'(a);
    #1;
    v = int'(rd_data);
  endtask

  task automatic wait_trig(input int ch, output int at);
    at = -1;
    for (int k = 0; k < 2000; k++) begin
      @(posedge clk); #1;
      if (trig[ch]) begin at = cyc; break; end
    end
  endtask

  task automatic t_reset;
    int v;
    for (int a = 0; a < 16; a++) begin
      rd(a, v);
      chk(v == 0, "R1 register reset", v, 0);
    end
    chk(irq == 1'b0, "R1 irq reset", int'(irq), 0);
    chk(trig == 4'b0, "R1 trig reset", int'(trig), 0);
  endtask

  task automatic t_period;
    int e0, t1, t2, v;
    wr(6, 1); wr(8, 2); wr(1, 1); wr(3, 0); wr(2, 1);
    wr(0, 1);
    e0 = cyc;
    wait_trig(0, t1);
    chk(t1 - e0 == 7, "R2 first timeout latency", t1 - e0, 7);
    @(posedge clk); #1;
    chk(trig[0] == 1'b0, "R7 trigger one clock wide", int'(trig[0]), 0);
    rd(5, v);
    chk(v[0] == 1'b1, "R7 flag set by timeout", v[0], 1);
    wait_trig(0, t2);
    chk(t2 - t1 == 6, "R2 period (M+1)*(C+1)", t2 - t1, 6);
    wr(2, 0);
  endtask

  task automatic t_flags;
    int v;
    wr(4, 0);
    chk(irq == 1'b0, "R6 masked flag gives no irq", int'(irq), 0);
    wr(4, 1);
    chk(irq == 1'b1, "R6 enabled flag raises irq", int'(irq), 1);
    wr(5, 0);
    rd(5, v);
    chk(v[0] == 1'b1, "R5 writing 0 keeps flag", v[0], 1);
    wr(5, 1);
    rd(5, v);
    chk(v[0] == 1'b0, "R5 writing 1 clears flag", v[0], 0);
    chk(irq == 1'b0, "R6 irq drops with flag", int'(irq), 0);
  endtask

  task automatic t_hold;
    int a, b;
    rd(9, a);
    repeat (20) @(posedge clk);
    rd(9, b);
    chk(a == b, "R4 disabled channel holds count", b, a);
    wr(0, 0); wr(2, 1);
    rd(9, a);
    repeat (20) @(posedge clk);
    rd(9, b);
    chk(a == b, "R4 global stop holds count", b, a);
    wr(2, 0); wr(0, 1);
    wr(9, 16'h1234);
    rd(9, b);
    chk(a == b, "R11 count register ignores writes", b, a);
  endtask

  task automatic t_mux;
    int e0, t1, t2;
    wr(7, 0); wr(10, 3); wr(3, 2); wr(1, 2);
    wr(2, 2);
    e0 = cyc;
    wait_trig(1, t1);
    chk(t1 - e0 == 5, "R3 channel follows prescaler 1 latency", t1 - e0, 5);
    wait_trig(1, t2);
    chk(t2 - t1 == 4, "R3 period from prescaler 1", t2 - t1, 4);
    wr(2, 0);
  endtask

  task automatic t_chforce;
    int v;
    wr(5, 15); wr(10, 9); wr(1, 2);
    rd(11, v);
    chk(v == 9, "R8 force loads channel count", v, 9);
    rd(5, v);
    chk(v == 0, "R8 force sets no flag", v, 0);
    rd(1, v);
    chk(v == 0, "R8 force bits read zero", v, 0);
  endtask

  task automatic t_collide;
    int t0;
    wr(6, 3); wr(8, 0); wr(1, 1); wr(3, 0); wr(4, 1);
    wr(2, 1);
    wait_trig(0, t0);
    wr(5, 1);
    chk(irq == 1'b0, "R5 clear between timeouts", int'(irq), 0);
    @(posedge clk);
    @(posedge clk);
    wr(5, 1);
    chk(irq == 1'b1, "R10 timeout beats same-edge clear", int'(irq), 1);
  endtask

  task automatic t_psforce;
    int t2, t3, t4, v;
    wait_trig(0, t2);
    wr(0, 3);
    wait_trig(0, t3);
    chk(t3 - t2 == 5, "R9 prescaler force restarts count", t3 - t2, 5);
    rd(0, v);
    chk(v == 1, "R9 prescaler force bits read zero", v, 1);
    wait_trig(0, t4);
    chk(t4 - t3 == 4, "R9 normal period after force", t4 - t3, 4);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_period();
    t_flags();
    t_hold();
    t_mux();
    t_chforce();
    t_collide();
    t_psforce();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule